// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This unit turns a segmented logical address into a 32-bit linear address. It holds six segment registers. Each register keeps a local copy of its segment's descriptor: base, limit, privilege, a read-only flag and a null marker. Software loads a register by presenting a selector. The unit then reads the 8-byte descriptor from a global or a local table in memory, as two 32-bit words over a simple read port, and stalls further loads until both words have arrived.

After a register is loaded, every access through it is translated and checked using only the local copy, so there are no extra memory cycles. The base is added to the 32-bit offset. In the same cycle the unit checks the null marker, the current privilege, the limit and write permission, and reports either the linear address or a fault code with the selector of the register at fault.

The current privilege level is the privilege of the descriptor held in the code register (register 1). A load that fails keeps the register's previous contents.

Top module: `seg_xlate_unit`

## Requirements
- R1: After a synchronous reset every register is marked null with privilege 0. The current privilege is 0, `ld_busy`, `mem_rd`, `ld_done` and `acc_done` are low, and an access through any register reports the null fault.
- R2: A selector is 14 bits. Bit 0 picks the table (0 = global at `gtab_base`, 1 = local at `ltab_base`) and bits 13:1 are the entry index. The descriptor is read at table base + index*8 and then at that address + 4.
- R3: The cycle after a load is accepted, `mem_rd` and `ld_busy` are high. `mem_addr` holds steady until `mem_rvalid`. `ld_done` pulses for one cycle, with `ld_code`, in the cycle after the second word is returned.
- R4: The first descriptor word is the 32-bit base. In the second word, bits 27:0 are the limit, bits 29:28 are the privilege level, bit 30 is present and bit 31 is read-only.
- R5: `acc_done` is high the cycle after `acc_valid`. On success `acc_fault` is 0, `acc_code` is 0 and `acc_lin` equals base + offset.
- R6: An offset greater than the limit gives code 4. An offset equal to the limit is allowed.
- R7: A write through a read-only register gives code 5. A read through the same register is allowed.
- R8: Selector 0 (global, index 0) loads with no memory read and `ld_code` 0. Any access through that register, or through a register number of 6 or more, gives code 1.
- R9: A descriptor with present clear makes the load end with `ld_code` 2, and the register keeps its previous contents.
- R10: The current privilege level equals the privilege of the code register (register 1). Loading a non-code register whose descriptor privilege is numerically below the current level ends with `ld_code` 3 and leaves that register unchanged. Loading the code register skips this check. An access where the current level exceeds the register's privilege gives code 3.
- R11: A load request made while `ld_busy` is high is ignored.
- R12: When several access checks fail, the code reported is the first of null, privilege, limit, write, in that order. `acc_sel` carries the register's selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gtab_base | input | 32 | Global table base address |
| ltab_base | input | 32 | Local table base address |
| ld_valid | input | 1 | Load request |
| ld_seg | input | 3 | Register to load |
| ld_sel | input | 14 | Selector to load |
| ld_busy | output | 1 | Descriptor fetch in progress |
| ld_done | output | 1 | Load finished (one-cycle pulse) |
| ld_code | output | 3 | Load result code |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| acc_valid | input | 1 | Access request |
| acc_seg | input | 3 | Register used by the access |
| acc_off | input | 32 | Access offset |
| acc_wr | input | 1 | Access is a write |
| acc_done | output | 1 | Access result valid |
| acc_fault | output | 1 | Access faulted |
| acc_code | output | 3 | Access fault code |
| acc_sel | output | 14 | Selector of the register used |
| acc_lin | output | 32 | Linear address (0 on fault) |

## Verification
A corrupted copy of a descriptor shows up on the very next access through that register: as a wrong `acc_lin`, or as a fault code that does not follow from the stored limit, privilege or read-only flag. A load that fails but still overwrites its register is caught by an access issued right after `ld_done`. A wrong current privilege level shows up one cycle after any access to a register whose privilege differs from the code register's. Fetch state errors show up within two cycles of a load, as a wrong `mem_addr` sequence or a missing `ld_done` pulse.

// File: rtl/segxl_pkg.sv
package segxl_pkg;
  parameter int IDX_W = 13;
  localparam int SEL_W = IDX_W + 1;
  localparam int LIM_W = 28;

  typedef enum logic [2:0] {
    FC_OK    = 3'd0,
    FC_NULL  = 3'd1,
    FC_NOTP  = 3'd2,
    FC_PRIV  = 3'd3,
    FC_LIMIT = 3'd4,
    FC_WRITE = 3'd5
  } fcode_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [31:0]      base;
    logic [LIM_W-1:0] limit;
    logic [1:0]       dpl;
    logic             ro;
    logic             nul;
  } seg_ent_t;

  localparam seg_ent_t ENT_NULL = '{sel: '0, base: '0, limit: '0,
                                    dpl: 2'd0, ro: 1'b0, nul: 1'b1};
endpackage

// File: rtl/seg_fetch.sv
module seg_fetch
  import segxl_pkg::*;
#(
  parameter int NSEG     = 6,
  parameter int SEGW     = 3,
  parameter int CODE_SEG = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      gtab_base,
  input  logic [31:0]      ltab_base,
  input  logic             ld_valid,
  input  logic [SEGW-1:0]  ld_seg,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic [1:0]       cpl,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             ld_busy,
  output logic             ld_done,
  output logic [2:0]       ld_code,
  output logic             mem_rd,
  output logic [31:0]      mem_addr,
  output logic             wr_en,
  output logic [SEGW-1:0]  wr_seg,
  output seg_ent_t         wr_ent
);
  localparam int PAD_W = 32 - IDX_W - 3;

  typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fst_e;
  fst_e st;

  logic [SEGW-1:0]  seg_q;
  logic [SEL_W-1:0] sel_q;
  logic [31:0]      base_q;
  logic             take, is_null, hi_ok;
  logic [1:0]       d_dpl;
  logic [31:0]      ent_off;

  assign take    = (st == F_IDLE) && ld_valid;
  assign is_null = (ld_sel == '0);
  assign d_dpl   = mem_rdata[29:28];
  assign ent_off = {{PAD_W{1'b0}}, ld_sel[SEL_W-1:1], 3'b000};
  assign hi_ok   = mem_rdata[30] && ((seg_q == SEGW'(CODE_SEG)) || (cpl <= d_dpl));
  assign ld_busy = (st != F_IDLE);
  assign mem_rd  = (st != F_IDLE);

  always_comb begin
    wr_en  = (take && is_null) || ((st == F_HI) && mem_rvalid && hi_ok);
    wr_seg = (st == F_IDLE) ? ld_seg : seg_q;
    if (st == F_IDLE) wr_ent = ENT_NULL;
    else wr_ent = '{sel: sel_q, base: base_q, limit: mem_rdata[LIM_W-1:0],
                    dpl: d_dpl, ro: mem_rdata[31], nul: 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= F_IDLE;
      ld_done  <= 1'b0;
      ld_code  <= 3'd0;
      mem_addr <= '0;
      seg_q    <= '0;
      sel_q    <= '0;
      base_q   <= '0;
    end else begin
      ld_done <= 1'b0;
      case (st)
        F_IDLE: if (ld_valid) begin
          seg_q <= ld_seg;
          sel_q <= ld_sel;
          if (is_null) begin
            ld_done <= 1'b1;
            ld_code <= FC_OK;
          end else begin
            mem_addr <= (ld_sel[0] ? ltab_base : gtab_base) + ent_off;
            st       <= F_LO;
          end
        end
        F_LO: if (mem_rvalid) begin
          base_q   <= mem_rdata;
          mem_addr <= mem_addr + 32'd4;
          st       <= F_HI;
        end
        F_HI: if (mem_rvalid) begin
          st      <= F_IDLE;
          ld_done <= 1'b1;
          if (!mem_rdata[30]) ld_code <= FC_NOTP;
          else if (!hi_ok)    ld_code <= FC_PRIV;
          else                ld_code <= FC_OK;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  // R3
  hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_rvalid) |=> (mem_rd && $stable(mem_addr)));

  // R2
  second_word_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == F_LO) && mem_rvalid) |=> (mem_rd && (mem_addr == $past(mem_addr) + 32'd4)));

  // R11
  done_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_done, ld_busy}));
endmodule

// File: rtl/seg_cache.sv
module seg_cache
  import segxl_pkg::*;
#(
  parameter int NSEG = 6,
  parameter int SEGW = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [SEGW-1:0]       wr_seg,
  input  seg_ent_t              wr_ent,
  output seg_ent_t [NSEG-1:0]   ents
);
  seg_ent_t ent_r [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) ent_r[g] <= ENT_NULL;
      else if (wr_en && (wr_seg == SEGW'(g))) ent_r[g] <= wr_ent;
    end
    assign ents[g] = ent_r[g];
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import segxl_pkg::*;
#(
  parameter int NSEG = 6,
  parameter int SEGW = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  seg_ent_t [NSEG-1:0] ents,
  input  logic [1:0]          cpl,
  input  logic                acc_valid,
  input  logic [SEGW-1:0]     acc_seg,
  input  logic [31:0]         acc_off,
  input  logic                acc_wr,
  output logic                acc_done,
  output logic                acc_fault,
  output logic [2:0]          acc_code,
  output logic [SEL_W-1:0]    acc_sel,
  output logic [31:0]         acc_lin
);
  seg_ent_t ent;
  fcode_e   c;

  always_comb begin
    ent = ENT_NULL;
    for (int i = 0; i < NSEG; i++)
      if (acc_seg == SEGW'(i)) ent = ents[i];
    if (ent.nul)                                          c = FC_NULL;
    else if (cpl > ent.dpl)                               c = FC_PRIV;
    else if (acc_off > {{(32-LIM_W){1'b0}}, ent.limit})   c = FC_LIMIT;
    else if (acc_wr && ent.ro)                            c = FC_WRITE;
    else                                                  c = FC_OK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_done  <= 1'b0;
      acc_fault <= 1'b0;
      acc_code  <= 3'd0;
      acc_sel   <= '0;
      acc_lin   <= '0;
    end else begin
      acc_done  <= acc_valid;
      acc_fault <= acc_valid && (c != FC_OK);
      if (acc_valid) begin
        acc_code <= c;
        acc_sel  <= ent.sel;
        acc_lin  <= (c == FC_OK) ? ent.base + acc_off : 32'd0;
      end
    end
  end

  // R5
  resp_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> acc_done);

  // R5
  ok_code_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_done && !acc_fault) |-> (acc_code == 3'd0));
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import segxl_pkg::*;
#(
  parameter int NSEG     = 6,
  parameter int CODE_SEG = 1,
  localparam int SEGW    = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      gtab_base,
  input  logic [31:0]      ltab_base,
  input  logic             ld_valid,
  input  logic [SEGW-1:0]  ld_seg,
  input  logic [SEL_W-1:0] ld_sel,
  output logic             ld_busy,
  output logic             ld_done,
  output logic [2:0]       ld_code,
  output logic             mem_rd,
  output logic [31:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  input  logic             acc_valid,
  input  logic [SEGW-1:0]  acc_seg,
  input  logic [31:0]      acc_off,
  input  logic             acc_wr,
  output logic             acc_done,
  output logic             acc_fault,
  output logic [2:0]       acc_code,
  output logic [SEL_W-1:0] acc_sel,
  output logic [31:0]      acc_lin
);
  seg_ent_t [NSEG-1:0] ents;
  logic                wr_en;
  logic [SEGW-1:0]     wr_seg;
  seg_ent_t            wr_ent;
  logic [1:0]          cpl;

  assign cpl = ents[CODE_SEG].dpl;

  seg_fetch #(.NSEG(NSEG), .SEGW(SEGW), .CODE_SEG(CODE_SEG)) u_fetch (
    .clk(clk), .rst(rst), .gtab_base(gtab_base), .ltab_base(ltab_base),
    .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel), .cpl(cpl),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .ld_busy(ld_busy),
    .ld_done(ld_done), .ld_code(ld_code), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .wr_en(wr_en), .wr_seg(wr_seg), .wr_ent(wr_ent)
  );

  seg_cache #(.NSEG(NSEG), .SEGW(SEGW)) u_cache (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_seg(wr_seg), .wr_ent(wr_ent),
    .ents(ents)
  );

  seg_check #(.NSEG(NSEG), .SEGW(SEGW)) u_check (
    .clk(clk), .rst(rst), .ents(ents), .cpl(cpl), .acc_valid(acc_valid),
    .acc_seg(acc_seg), .acc_off(acc_off), .acc_wr(acc_wr),
    .acc_done(acc_done), .acc_fault(acc_fault), .acc_code(acc_code),
    .acc_sel(acc_sel), .acc_lin(acc_lin)
  );

  // R9 R10
  keep_on_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_done && (ld_code != 3'd0)) |-> (ents == $past(ents)));
endmodule

// File: tb/sim_seg_xlate_unit.sv
`timescale 1ns/1ps
module sim_seg_xlate_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] gtab_base = 32'h40, ltab_base = 32'h80;
  logic        ld_valid = 1'b0;
  logic [2:0]  ld_seg = '0;
  logic [13:0] ld_sel = '0;
  logic        ld_busy, ld_done, mem_rd, mem_rvalid;
  logic [2:0]  ld_code, acc_code;
  logic [31:0] mem_addr, mem_rdata, acc_lin;
  logic        acc_valid = 1'b0, acc_wr = 1'b0;
  logic [2:0]  acc_seg = '0;
  logic [31:0] acc_off = '0;
  logic        acc_done, acc_fault;
  logic [13:0] acc_sel;

  int n_run = 0, n_fail = 0;
  logic [31:0] mem [0:63];

  always #5 clk = ~clk;

  assign mem_rvalid = mem_rd;
  assign mem_rdata  = mem[mem_addr[7:2]];

  seg_xlate_unit u0 (.*);

  function automatic logic [31:0] w1(input logic ro, input logic p,
                                     input logic [1:0] dpl, input logic [27:0] lim);
    return {ro, p, dpl, lim};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [2:0] seg, input logic [13:0] sel,
                         input logic [31:0] exp_addr, input logic [2:0] exp_code,
                         input string tag);
    @(negedge clk);
    ld_valid = 1'b1; ld_seg = seg; ld_sel = sel;
    @(posedge clk); #1;
    ld_valid = 1'b0;
    if (sel == 14'd0) begin
      chk({tag, " null no read"}, {31'd0, mem_rd}, 32'd0);
      chk({tag, " done"}, {31'd0, ld_done}, 32'd1);
      chk({tag, " code"}, {29'd0, ld_code}, {29'd0, exp_code});
    end else begin
      chk({tag, " busy"}, {31'd0, ld_busy}, 32'd1);
      chk({tag, " addr0"}, mem_addr, exp_addr);
      @(posedge clk); #1;
      chk({tag, " addr1"}, mem_addr, exp_addr + 32'd4);
      @(posedge clk); #1;
      chk({tag, " done"}, {30'd0, ld_done, ld_busy}, 32'd2);
      chk({tag, " code"}, {29'd0, ld_code}, {29'd0, exp_code});
    end
  endtask

  task automatic do_acc(input logic [2:0] seg, input logic [31:0] off, input logic wr,
                        input logic [2:0] exp_code, input logic [31:0] exp_lin,
                        input logic [13:0] exp_sel, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_seg = seg; acc_off = off; acc_wr = wr;
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_wr = 1'b0;
    chk({tag, " done/fault"}, {30'd0, acc_done, acc_fault}, {30'd0, 1'b1, exp_code != 3'd0});
    chk({tag, " code"}, {29'd0, acc_code}, {29'd0, exp_code});
    if (exp_code == 3'd0) chk({tag, " lin"}, acc_lin, exp_lin);
    else chk({tag, " sel"}, {18'd0, acc_sel}, {18'd0, exp_sel});
  endtask

  task automatic t_reset();
    chk("R1 busy/rd/done", {28'd0, ld_busy, mem_rd, ld_done, acc_done}, 32'd0);
    do_acc(3'd0, 32'd0, 1'b0, 3'd1, 32'd0, 14'd0, "R1 reset access null");
    do_acc(3'd1, 32'd4, 1'b0, 3'd1, 32'd0, 14'd0, "R1 reset code reg null");
  endtask

  task automatic t_basic();
    do_load(3'd1, 14'd2, 32'h48, 3'd0, "R2 R3 R4 load code reg");
    do_acc(3'd1, 32'h20, 1'b0, 3'd0, 32'h1020, 14'd2, "R5 translate");
    do_acc(3'd1, 32'hFF, 1'b1, 3'd0, 32'h10FF, 14'd2, "R6 at limit");
    do_acc(3'd1, 32'h100, 1'b0, 3'd4, 32'd0, 14'd2, "R6 over limit");
  endtask

  task automatic t_readonly();
    do_load(3'd2, 14'd4, 32'h50, 3'd0, "R4 load ro");
    do_acc(3'd2, 32'h10, 1'b1, 3'd5, 32'd0, 14'd4, "R7 write ro");
    do_acc(3'd2, 32'h10, 1'b0, 3'd0, 32'h20010, 14'd4, "R7 read ro");
  endtask

  task automatic t_local_notp();
    do_load(3'd3, 14'd3, 32'h88, 3'd0, "R2 local table");
    do_acc(3'd3, 32'hFFF, 1'b0, 3'd0, 32'h5FFF, 14'd3, "R2 local translate");
    do_load(3'd3, 14'd6, 32'h58, 3'd2, "R9 not present");
    do_acc(3'd3, 32'h0, 1'b0, 3'd0, 32'h5000, 14'd3, "R9 reg unchanged");
  endtask

  task automatic t_null();
    do_load(3'd5, 14'd0, 32'd0, 3'd0, "R8 null load");
    do_acc(3'd5, 32'h0, 1'b0, 3'd1, 32'd0, 14'd0, "R8 null access");
    do_acc(3'd7, 32'h0, 1'b0, 3'd1, 32'd0, 14'd0, "R8 bad reg number");
  endtask

  task automatic t_busy_ignore();
    @(negedge clk);
    ld_valid = 1'b1; ld_seg = 3'd4; ld_sel = 14'd10;
    @(posedge clk); #1;
    ld_sel = 14'd3; ld_seg = 3'd0;
    chk("R11 first addr", mem_addr, 32'h68);
    @(posedge clk); #1;
    ld_valid = 1'b0;
    chk("R11 second addr", mem_addr, 32'h6C);
    @(posedge clk); #1;
    chk("R11 done", {30'd0, ld_done, ld_busy}, 32'd2);
    @(posedge clk); #1;
    chk("R11 single done", {30'd0, ld_done, ld_busy}, 32'd0);
    do_acc(3'd4, 32'h10, 1'b0, 3'd0, 32'h410, 14'd10, "R11 first load kept");
    do_acc(3'd0, 32'h10, 1'b0, 3'd1, 32'd0, 14'd0, "R11 ignored reg untouched");
  endtask

  task automatic t_priv();
    do_load(3'd1, 14'd8, 32'h60, 3'd0, "R10 code reg load no check");
    do_acc(3'd1, 32'h10, 1'b1, 3'd0, 32'h310, 14'd8, "R10 code reg access");
    do_acc(3'd2, 32'h10, 1'b0, 3'd0, 32'h20010, 14'd4, "R10 equal privilege");
    do_acc(3'd3, 32'h10, 1'b0, 3'd3, 32'd0, 14'd3, "R10 access priv fault");
    do_load(3'd5, 14'd10, 32'h68, 3'd3, "R10 load priv fault");
    do_acc(3'd5, 32'h0, 1'b0, 3'd1, 32'd0, 14'd0, "R10 reg unchanged");
  endtask

  task automatic t_priority();
    do_acc(3'd2, 32'h10000, 1'b1, 3'd4, 32'd0, 14'd4, "R12 limit before write");
    do_acc(3'd3, 32'h2000, 1'b1, 3'd3, 32'd0, 14'd3, "R12 priv before limit");
    do_acc(3'd5, 32'h2000, 1'b1, 3'd1, 32'd0, 14'd0, "R12 null first");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    mem[18] = 32'h1000;  mem[19] = w1(1'b0, 1'b1, 2'd0, 28'hFF);
    mem[20] = 32'h20000; mem[21] = w1(1'b1, 1'b1, 2'd3, 28'hFFFF);
    mem[22] = 32'h7000;  mem[23] = w1(1'b0, 1'b0, 2'd0, 28'hFF);
    mem[24] = 32'h300;   mem[25] = w1(1'b0, 1'b1, 2'd3, 28'h10);
    mem[26] = 32'h400;   mem[27] = w1(1'b0, 1'b1, 2'd0, 28'hFF);
    mem[34] = 32'h5000;  mem[35] = w1(1'b0, 1'b1, 2'd2, 28'hFFF);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_basic();
    t_readonly();
    t_local_notp();
    t_null();
    t_busy_ignore();
    t_priv();
    t_priority();
    repeat (2) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule